// File: doc/BRIEF.md
# Serial Gamepad Adapter Reader

This block sits beside a general-purpose output port and turns two bits that software writes into that port into the latch and clock of a serial gamepad. Software pulses the latch to restart a frame, then toggles the clock to walk through the pad's buttons. The block keeps its own bit position and drives one data bit, which the surrounding logic presents as bit 7 of a fire-button input register.

Every port write is compared with the previous write to find changes on the latch and clock bits. A change on the latch restarts the frame and shows button 0. A rising clock edge moves the position forward but leaves the output alone. A falling clock edge shows the button at the current position, wrapping to 0 first once the position reaches 17. The adapter acts only while the configuration selects this pad type. At other times writes are still remembered, but they never change the output.

Top module: `serial_pad_reader`

## Requirements
- R1: After reset the output `pad_data` is 0, the bit position is 0 and the remembered latch and clock values are both 0.
- R2: While enabled, a write whose bit 5 (latch) differs from the previously written bit 5 sets the position to 0, and `pad_data` equals `buttons[0]` in the cycle after the write.
- R3: While enabled, a write where bit 4 (clock) goes from 0 to 1 adds one to the position and leaves `pad_data` unchanged.
- R4: While enabled, a write where bit 4 goes from 1 to 0 makes `pad_data` equal `buttons[p]` in the cycle after the write, where p is the current position.
- R5: On a 1-to-0 clock change with the position at 17 or more, the position first becomes 0, so `pad_data` shows `buttons[0]`. The next rising clock edge then moves the position to 1.
- R6: A position at or above the width of `buttons` presents 0. With the default width of 16, position 16 reads 0.
- R7: While `pad_sel` is 0, writes never change `pad_data`. The remembered latch and clock values still follow every write, so the first write after re-enabling is compared against the last write made while disabled.
- R8: In a cycle without `port_wr`, `pad_data` holds its value.
- R9: A write that changes latch and clock together is handled as the latch change first and the clock edge second. With a rising clock the position ends at 1; with a falling clock it ends at 0. In both cases `pad_data` shows `buttons[0]`.
- R10: Write bits other than 5 and 4 have no effect on the position or on `pad_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pad_sel | input | 1 | Configuration selects the serial pad; 1 enables the adapter |
| port_wr | input | 1 | One-cycle strobe for a write to the port data register |
| port_wdata | input | 8 | Written data; bit 5 is the latch, bit 4 is the clock |
| buttons | input | NBTN | Pad button states, bit i read at position i |
| pad_data | output | 1 | Selected button bit, shown as bit 7 of the input register |

## Verification
A latch change and a clock edge can come in the same write, so the restart and the shift must both be resolved in one cycle. The bench provokes this with writes that flip bits 5 and 4 together, once with a rising clock and once with a falling clock. It judges the result by the output right after the write, and by the button that appears after the following clock edges, which shows where the position ended. A second collision happens when a falling edge arrives with the position at 17: the wrap and the presentation of a button share that cycle. This case is judged by checking that button 0, not an out-of-range bit, reaches the output.

// File: rtl/serial_pad_pkg.sv
// Package: shared constants and types for the serial gamepad reader.
// Assumes: one latch bit and one clock bit inside an 8-bit port write.
package serial_pad_pkg;
    localparam int PORT_W = 8;

    // Edge events decoded from one port write
    typedef struct packed {
        logic latch_chg;
        logic clk_rise;
        logic clk_fall;
    } pad_edges_t;
endpackage

// File: rtl/pad_edge_detect.sv
// Module: pad_edge_detect
// Remembers the last written latch and clock bits and flags changes on a
// new write. Assumes writes are single-cycle strobes; the remembered bits
// follow every write whether or not the adapter is enabled.
module pad_edge_detect
    import serial_pad_pkg::*;
#(
    parameter int LATCH_BIT = 5,
    parameter int CLK_BIT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [PORT_W-1:0] wdata,
    output pad_edges_t        edges,
    output logic              lat_q,
    output logic              ck_q
);
    logic new_lat;
    logic new_ck;

    assign new_lat = wdata[LATCH_BIT];
    assign new_ck  = wdata[CLK_BIT];

    // Purpose: hold the previously written latch and clock bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= 1'b0;
            ck_q  <= 1'b0;
        end else if (wr) begin
            lat_q <= new_lat;
            ck_q  <= new_ck;
        end
    end

    // Purpose: decode change events for the current write
    always_comb begin
        edges.latch_chg = wr && (new_lat != lat_q);
        edges.clk_rise  = wr && new_ck && !ck_q;
        edges.clk_fall  = wr && !new_ck && ck_q;
    end
endmodule

// File: rtl/pad_bit_counter.sv
// Module: pad_bit_counter
// Tracks the serial bit position. A latch change is applied first, then a
// clock edge. Rising adds one and saturates at the counter's top value.
// Falling wraps to 0 at WRAP_POS or above. Also reports which position to
// present and when to present it.
module pad_bit_counter
    import serial_pad_pkg::*;
#(
    parameter int WRAP_POS = 17,
    localparam int PW      = $clog2(WRAP_POS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  pad_edges_t    edges,
    output logic [PW-1:0] pos_q,
    output logic [PW-1:0] show_pos,
    output logic          show
);
    localparam logic [PW-1:0] WRAP_V = PW'(WRAP_POS);
    localparam logic [PW-1:0] TOP_V  = {PW{1'b1}};

    logic [PW-1:0] base;
    logic [PW-1:0] wrapped;
    logic [PW-1:0] pos_d;

    // Purpose: resolve latch-then-clock ordering into the next position
    always_comb begin
        base    = edges.latch_chg ? '0 : pos_q;
        wrapped = (base >= WRAP_V) ? '0 : base;
        pos_d   = pos_q;
        if (en) begin
            if (edges.clk_rise)
                pos_d = (base == TOP_V) ? base : base + 1'b1;
            else if (edges.clk_fall)
                pos_d = wrapped;
            else
                pos_d = base;
        end
        show_pos = wrapped;
        show     = en && (edges.latch_chg || edges.clk_fall);
    end

    // Purpose: hold the current bit position
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else
            pos_q <= pos_d;
    end
endmodule

// File: rtl/pad_bit_select.sv
// Module: pad_bit_select
// Picks one button bit by position; positions at or above NBTN give 0.
// Assumes the position is an unsigned count.
module pad_bit_select #(
    parameter int NBTN = 16,
    parameter int PW   = 5
) (
    input  logic [NBTN-1:0] buttons,
    input  logic [PW-1:0]   pos,
    output logic            bit_out
);
    logic [NBTN-1:0] hot;

    // Purpose: one-hot gate each button by its position match
    for (genvar i = 0; i < NBTN; i++) begin : g_sel
        assign hot[i] = buttons[i] && (int'(pos) == i);
    end

    assign bit_out = |hot;
endmodule

// File: rtl/serial_pad_reader.sv
// Module: serial_pad_reader (top)
// Turns port writes into latch and clock events for a serial pad and
// registers the selected button as the fire-input bit 7. Assumes the port
// writes arrive as one-cycle strobes in the clk domain.
module serial_pad_reader
    import serial_pad_pkg::*;
#(
    parameter int NBTN      = 16,
    parameter int WRAP_POS  = 17,
    parameter int LATCH_BIT = 5,
    parameter int CLK_BIT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pad_sel,
    input  logic              port_wr,
    input  logic [PORT_W-1:0] port_wdata,
    input  logic [NBTN-1:0]   buttons,
    output logic              pad_data
);
    localparam int PW = $clog2(WRAP_POS + 1);

    pad_edges_t    edges;
    logic          lat_q;
    logic          ck_q;
    logic [PW-1:0] pos_q;
    logic [PW-1:0] show_pos;
    logic          show;
    logic          sel_bit;

    pad_edge_detect #(
        .LATCH_BIT (LATCH_BIT),
        .CLK_BIT   (CLK_BIT)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (port_wr),
        .wdata (port_wdata),
        .edges (edges),
        .lat_q (lat_q),
        .ck_q  (ck_q)
    );

    pad_bit_counter #(
        .WRAP_POS (WRAP_POS)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (pad_sel),
        .edges    (edges),
        .pos_q    (pos_q),
        .show_pos (show_pos),
        .show     (show)
    );

    pad_bit_select #(
        .NBTN (NBTN),
        .PW   (PW)
    ) u_sel (
        .buttons (buttons),
        .pos     (show_pos),
        .bit_out (sel_bit)
    );

    // Purpose: register the presented button bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            pad_data <= 1'b0;
        else if (show)
            pad_data <= sel_bit;
    end
endmodule

// File: rtl/serial_pad_reader_chk.sv
// Module: serial_pad_reader_chk
// Property checker bound into serial_pad_reader.
module serial_pad_reader_chk #(
    parameter int NBTN      = 16,
    parameter int WRAP_POS  = 17,
    parameter int LATCH_BIT = 5,
    parameter int CLK_BIT   = 4,
    parameter int PW        = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pad_sel,
    input logic            port_wr,
    input logic [7:0]      port_wdata,
    input logic [NBTN-1:0] buttons,
    input logic            pad_data,
    input logic            lat_q,
    input logic            ck_q,
    input logic [PW-1:0]   pos_q
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!pad_data && pos_q == '0 && !lat_q && !ck_q)); // R1

    AST_LATCH_SHOWS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && pad_sel && port_wdata[LATCH_BIT] != lat_q) |=> pad_data == $past(buttons[0])); // R2

    AST_RISE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && pad_sel && port_wdata[LATCH_BIT] == lat_q && port_wdata[CLK_BIT] && !ck_q) |=> $stable(pad_data)); // R3

    AST_FALL_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && pad_sel && port_wdata[LATCH_BIT] == lat_q && !port_wdata[CLK_BIT] && ck_q) |=> int'(pos_q) < WRAP_POS); // R5

    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_sel |=> $stable(pad_data)); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> $stable(pad_data)); // R8
endmodule

bind serial_pad_reader serial_pad_reader_chk #(
    .NBTN      (NBTN),
    .WRAP_POS  (WRAP_POS),
    .LATCH_BIT (LATCH_BIT),
    .CLK_BIT   (CLK_BIT),
    .PW        (PW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pad_sel    (pad_sel),
    .port_wr    (port_wr),
    .port_wdata (port_wdata),
    .buttons    (buttons),
    .pad_data   (pad_data),
    .lat_q      (lat_q),
    .ck_q       (ck_q),
    .pos_q      (pos_q)
);

// File: tb/sim_serial_pad_reader.sv
`timescale 1ns/1ps
module sim_serial_pad_reader;
    localparam int NBTN = 16;
    localparam int WRAP = 17;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pad_sel = 1'b1;
    logic            port_wr = 1'b0;
    logic [7:0]      port_wdata = '0;
    logic [NBTN-1:0] buttons = '0;
    logic            pad_data;

    int n_chk = 0;
    int n_bad = 0;

    // reference state, derived from the requirements
    int   m_pos = 0;
    logic m_lat = 1'b0;
    logic m_ck  = 1'b0;
    logic m_out = 1'b0;

    always #5 clk = ~clk;

    serial_pad_reader u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pad_sel    (pad_sel),
        .port_wr    (port_wr),
        .port_wdata (port_wdata),
        .buttons    (buttons),
        .pad_data   (pad_data)
    );

    function automatic logic btn_at(int p);
        return (p < NBTN) ? buttons[p] : 1'b0;
    endfunction

    task automatic check(string req, logic exp);
        n_chk++;
        if (pad_data !== exp) begin
            n_bad++;
            $display("FAIL %s: pad_data=%b expected=%b", req, pad_data, exp);
        end
    endtask

    // one port write, reference update, then sample after the edge
    task automatic pwrite(logic [7:0] d, string req);
        if (pad_sel) begin
            if (d[5] != m_lat) begin
                m_pos = 0;
                m_out = btn_at(0);
            end
            if (d[4] && !m_ck) begin
                m_pos = m_pos + 1;
            end else if (!d[4] && m_ck) begin
                if (m_pos >= WRAP) m_pos = 0;
                m_out = btn_at(m_pos);
            end
        end
        m_lat = d[5];
        m_ck  = d[4];
        @(negedge clk);
        port_wr = 1'b1;
        port_wdata = d;
        @(negedge clk);
        port_wr = 1'b0;
        port_wdata = 8'h00;
        check(req, m_out);
    endtask

    task automatic clk_pulse(string req);
        pwrite({2'b00, m_lat, 1'b1, 4'h0}, req);
        pwrite({2'b00, m_lat, 1'b0, 4'h0}, req);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pos = 0; m_lat = 0; m_ck = 0; m_out = 0;
        @(negedge clk);
        check("R1", 1'b0);
    endtask

    task automatic t_latch;
        buttons = 16'hA5C3;
        pwrite(8'h20, "R2");
        pwrite(8'h00, "R2");
        buttons = 16'h0000;
        pwrite(8'h20, "R2");
    endtask

    task automatic t_frame;
        buttons = 16'h6B2D;
        pwrite({2'b00, ~m_lat, 5'h0}, "R2");
        for (int i = 0; i < 18; i++) begin
            pwrite({2'b00, m_lat, 1'b1, 4'h0}, "R3");
            pwrite({2'b00, m_lat, 1'b0, 4'h0}, (i == 15) ? "R6" : (i == 16) ? "R5" : "R4");
        end
    endtask

    task automatic t_wrap;
        buttons = 16'hFFFE;
        pwrite({2'b00, ~m_lat, 5'h0}, "R5");
        for (int i = 0; i < 17; i++) clk_pulse("R4");
        clk_pulse("R5");
    endtask

    task automatic t_combined;
        buttons = 16'h0005;
        pwrite({2'b00, ~m_lat, 5'h0}, "R9");
        clk_pulse("R9");
        pwrite({2'b00, ~m_lat, 1'b1, 4'h0}, "R9");
        pwrite({2'b00, m_lat, 1'b0, 4'h0}, "R9");
        pwrite({2'b00, m_lat, 1'b1, 4'h0}, "R9");
        pwrite({2'b00, ~m_lat, 1'b0, 4'h0}, "R9");
        clk_pulse("R9");
        clk_pulse("R9");
    endtask

    task automatic t_disabled;
        buttons = 16'h0002;
        pwrite({2'b00, ~m_lat, 5'h0}, "R7");
        pad_sel = 1'b0;
        pwrite({2'b00, ~m_lat, 5'h0}, "R7");
        pwrite({2'b00, m_lat, 1'b1, 4'h0}, "R7");
        pwrite({2'b00, m_lat, 1'b0, 4'h0}, "R7");
        pwrite({2'b00, m_lat, 1'b1, 4'h0}, "R7");
        pad_sel = 1'b1;
        pwrite({2'b00, m_lat, 1'b0, 4'h0}, "R7");
        clk_pulse("R7");
    endtask

    task automatic t_other_bits;
        buttons = 16'h0001;
        pwrite({2'b00, ~m_lat, 5'h0}, "R10");
        pwrite({2'b11, m_lat, 1'b0, 4'hF}, "R10");
        pwrite({2'b10, m_lat, 1'b0, 4'h5}, "R10");
        clk_pulse("R10");
    endtask

    task automatic t_idle;
        buttons = 16'h0001;
        pwrite({2'b00, ~m_lat, 5'h0}, "R8");
        buttons = 16'h0000;
        repeat (5) @(negedge clk);
        check("R8", 1'b1);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_latch();
        t_frame();
        t_wrap();
        t_combined();
        t_disabled();
        t_other_bits();
        t_idle();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule